// File: doc/BRIEF.md
# Wavefront Issue Arbiter

This block decides, every clock, which wavefronts of a compute unit issue an instruction. It has four SIMD units with eight wave slots each. A registered pointer rotates over the SIMDs, one SIMD per cycle. Each wave slot of the selected SIMD may present its next instruction. The block then grants at most one instruction in each of five categories: vector ALU, vector memory, scalar ALU or scalar memory, scratchpad (LDS) and branch.

Inside a category the candidate that has waited longest wins. Waiting time is kept in a saturating age counter for each slot. A category whose unit reports busy grants nothing. Scratchpad work has one extra rule. SIMDs 0/1 form one pair and SIMDs 2/3 form another. An LDS grant is withheld while the other SIMD of the same pair still has an LDS operation in flight.

All inputs are plain level signals that are sampled in the same cycle. Grants are combinational from the current pointer and the inputs. A wave that is not granted simply keeps its valid flag high and competes again four cycles later. There is no valid/ready handshake: back-pressure is given only by the per-category busy and per-SIMD LDS busy inputs.

Top module: `wave_issue_sched`

## Requirements
- R1: The SIMD pointer `sel_simd` advances by one (modulo 4) on every clock edge out of reset, whether or not anything issues. It reads 0 in the first cycle after reset is released.
- R2: Grants refer only to the slots of the SIMD named by `sel_simd`. Valid waves in other SIMDs produce no grant in that cycle.
- R3: Each category's 8-bit grant field `cat_grant[c*8 +: 8]` is zero or one-hot over the slots. The category codes are 0 vector ALU, 1 vector memory, 2 scalar ALU/memory, 3 LDS and 4 branch.
- R4: A wave slot receives at most one grant per cycle. When five valid slots carry the five distinct categories and nothing is busy, all five issue together and `issue_grant` shows all five slots.
- R5: Inside a category the eligible slot with the largest age wins. A tie goes to the lower slot index. A slot's age counts cycles spent valid and not granted, and is cleared when the slot is granted or not valid.
- R6: A slot that is not valid, that carries a category code of 5 to 7, or whose category has `cat_busy[c]` high, is never granted.
- R7: An LDS grant from SIMD s is suppressed while `lds_busy[s^1]` is high. The busy bit of the other pair has no effect.
- R8: Age counters saturate at 2^AGE_W-1. Two slots that have both reached saturation tie, and the lower index wins.
- R9: A synchronous reset clears every age counter and sets the pointer to SIMD 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wave_valid | input | NUM_SIMD*SLOTS_PER_SIMD | Slot has an instruction ready; bit simd*8+slot |
| wave_cat | input | NUM_SIMD*SLOTS_PER_SIMD*3 | 3-bit category code per slot, same ordering |
| cat_busy | input | 5 | Category unit cannot accept work this cycle |
| lds_busy | input | NUM_SIMD | SIMD has an LDS operation in flight |
| sel_simd | output | log2(NUM_SIMD) | SIMD considered this cycle |
| cat_grant | output | 5*SLOTS_PER_SIMD | One field of slot grants per category |
| issue_grant | output | SLOTS_PER_SIMD | OR of all category grants, per slot |

## Verification
The bench uses the default four SIMDs with eight slots each. It narrows AGE_W to 3, so an age counter saturates after seven waiting cycles. That makes the saturated-tie case reachable in a dozen cycles, next to the unsaturated oldest-first case. Ages are built up by holding a category busy while waves wait, and are then released on the target SIMD's turn. A reset that arrives while waves are still waiting shows that ages are cleared.

// File: rtl/wis_pkg.sv
package wis_pkg;
  localparam int NUM_CAT = 5;
  localparam int CAT_W   = 3;

  typedef enum logic [CAT_W-1:0] {
    CAT_VALU   = 3'd0,
    CAT_VMEM   = 3'd1,
    CAT_SCALAR = 3'd2,
    CAT_LDS    = 3'd3,
    CAT_BRANCH = 3'd4
  } cat_e;
endpackage

// File: rtl/simd_rr_ptr.sv
module simd_rr_ptr #(
  parameter int NUM_SIMD = 4,
  localparam int PTR_W = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1
) (
  input  logic             clk,
  input  logic             rst,
  output logic [PTR_W-1:0] ptr
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_SIMD - 1);

  always_ff @(posedge clk) begin
    if (rst)              ptr <= '0;
    else if (ptr == LAST) ptr <= '0;
    else                  ptr <= ptr + PTR_W'(1);
  end
endmodule

// File: rtl/wave_age_bank.sv
module wave_age_bank #(
  parameter int NUM_WAVES = 32,
  parameter int AGE_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_WAVES-1:0]       valid,
  input  logic [NUM_WAVES-1:0]       granted,
  output logic [NUM_WAVES*AGE_W-1:0] ages
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  for (genvar w = 0; w < NUM_WAVES; w++) begin : g_age
    logic [AGE_W-1:0] age_q;
    always_ff @(posedge clk) begin
      if (rst || !valid[w] || granted[w]) age_q <= '0;
      else if (age_q != AGE_MAX)          age_q <= age_q + AGE_W'(1);
    end
    assign ages[w*AGE_W +: AGE_W] = age_q;
  end
endmodule

// File: rtl/cat_oldest_pick.sv
module cat_oldest_pick #(
  parameter int SLOTS = 8,
  parameter int AGE_W = 4,
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SLOTS-1:0]       eligible,
  input  logic [SLOTS*AGE_W-1:0] ages,
  output logic [SLOTS-1:0]       pick
);
  logic             found;
  logic [AGE_W-1:0] best_age;
  logic [IDX_W-1:0] best_idx;

  always_comb begin
    found    = 1'b0;
    best_age = '0;
    best_idx = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (eligible[i] && (!found || ages[i*AGE_W +: AGE_W] > best_age)) begin
        found    = 1'b1;
        best_age = ages[i*AGE_W +: AGE_W];
        best_idx = IDX_W'(i);
      end
    end
    pick = '0;
    if (found) pick[best_idx] = 1'b1;
  end
endmodule

// File: rtl/wave_issue_sched.sv
module wave_issue_sched
  import wis_pkg::*;
#(
  parameter int NUM_SIMD       = 4,
  parameter int SLOTS_PER_SIMD = 8,
  parameter int AGE_W          = 4,
  localparam int PTR_W     = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1,
  localparam int NUM_WAVES = NUM_SIMD * SLOTS_PER_SIMD
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_WAVES-1:0]              wave_valid,
  input  logic [NUM_WAVES*CAT_W-1:0]        wave_cat,
  input  logic [NUM_CAT-1:0]                cat_busy,
  input  logic [NUM_SIMD-1:0]               lds_busy,
  output logic [PTR_W-1:0]                  sel_simd,
  output logic [NUM_CAT*SLOTS_PER_SIMD-1:0] cat_grant,
  output logic [SLOTS_PER_SIMD-1:0]         issue_grant
);
  localparam int S = SLOTS_PER_SIMD;

  logic [NUM_WAVES*AGE_W-1:0] ages_all;
  logic [NUM_WAVES-1:0]       granted_all;
  logic [S-1:0]               cur_valid;
  logic [S*CAT_W-1:0]         cur_cat;
  logic [S*AGE_W-1:0]         cur_age;
  logic                       partner_lds_busy;

  simd_rr_ptr #(.NUM_SIMD(NUM_SIMD)) u_ptr (
    .clk (clk),
    .rst (rst),
    .ptr (sel_simd)
  );

  wave_age_bank #(.NUM_WAVES(NUM_WAVES), .AGE_W(AGE_W)) u_age (
    .clk     (clk),
    .rst     (rst),
    .valid   (wave_valid),
    .granted (granted_all),
    .ages    (ages_all)
  );

  // Bring the selected SIMD's slots forward.
  always_comb begin
    for (int s = 0; s < S; s++) begin
      cur_valid[s]                 = wave_valid[int'(sel_simd)*S + s];
      cur_cat[s*CAT_W +: CAT_W]    = wave_cat[(int'(sel_simd)*S + s)*CAT_W +: CAT_W];
      cur_age[s*AGE_W +: AGE_W]    = ages_all[(int'(sel_simd)*S + s)*AGE_W +: AGE_W];
    end
    partner_lds_busy = lds_busy[sel_simd ^ PTR_W'(1)];
  end

  for (genvar c = 0; c < NUM_CAT; c++) begin : g_cat
    logic [S-1:0] elig;
    logic         blocked;
    if (c == int'(CAT_LDS)) begin : g_lds
      assign blocked = cat_busy[c] || partner_lds_busy;
    end else begin : g_plain
      assign blocked = cat_busy[c];
    end
    always_comb begin
      for (int s = 0; s < S; s++)
        elig[s] = cur_valid[s] && !blocked &&
                  (cur_cat[s*CAT_W +: CAT_W] == CAT_W'(c));
    end
    cat_oldest_pick #(.SLOTS(S), .AGE_W(AGE_W)) u_pick (
      .eligible (elig),
      .ages     (cur_age),
      .pick     (cat_grant[c*S +: S])
    );
  end

  always_comb begin
    issue_grant = '0;
    for (int c = 0; c < NUM_CAT; c++) issue_grant |= cat_grant[c*S +: S];
  end

  for (genvar w = 0; w < NUM_WAVES; w++) begin : g_gnt
    assign granted_all[w] = (int'(sel_simd) == w / S) && issue_grant[w % S];
  end
endmodule

// File: rtl/wis_checker.sv
module wis_checker
  import wis_pkg::*;
#(
  parameter int NUM_SIMD = 4,
  parameter int SLOTS    = 8,
  localparam int PTR_W   = (NUM_SIMD > 1) ? $clog2(NUM_SIMD) : 1,
  localparam int NW      = NUM_SIMD * SLOTS
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NW-1:0]            wave_valid,
  input logic [NW*CAT_W-1:0]      wave_cat,
  input logic [NUM_CAT-1:0]       cat_busy,
  input logic [NUM_SIMD-1:0]      lds_busy,
  input logic [PTR_W-1:0]         sel_simd,
  input logic [NUM_CAT*SLOTS-1:0] cat_grant,
  input logic [SLOTS-1:0]         issue_grant
);
  logic was_run;
  always_ff @(posedge clk) was_run <= !rst;

  logic [PTR_W-1:0] step_exp;
  assign step_exp = (int'(sel_simd) == NUM_SIMD - 1) ? '0 : sel_simd + PTR_W'(1);

  AST_RR_STEP: assert property (@(posedge clk) disable iff (rst)
    was_run |-> sel_simd == $past(step_exp)) else $error("rr step");      // R1
  AST_RST_PTR: assert property (@(posedge clk)
    rst |=> sel_simd == '0) else $error("reset ptr");                     // R9

  AST_LDS_PAIR: assert property (@(posedge clk) disable iff (rst)
    (|cat_grant[int'(CAT_LDS)*SLOTS +: SLOTS]) |-> !lds_busy[sel_simd ^ PTR_W'(1)])
    else $error("lds pair");                                             // R7

  for (genvar c = 0; c < NUM_CAT; c++) begin : g_c
    AST_CAT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(cat_grant[c*SLOTS +: SLOTS])) else $error("cat onehot");   // R3
    for (genvar s = 0; s < SLOTS; s++) begin : g_s
      AST_GRANT_ELIG: assert property (@(posedge clk) disable iff (rst)
        cat_grant[c*SLOTS + s] |->
          (wave_valid[int'(sel_simd)*SLOTS + s] && !cat_busy[c] &&
           wave_cat[(int'(sel_simd)*SLOTS + s)*CAT_W +: CAT_W] == CAT_W'(c)))
        else $error("grant elig");                                       // R6
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_w
    logic [NUM_CAT-1:0] per_slot;
    always_comb
      for (int c = 0; c < NUM_CAT; c++) per_slot[c] = cat_grant[c*SLOTS + s];
    AST_WAVE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      $countones(per_slot) <= 1 && issue_grant[s] == (|per_slot))
      else $error("wave single");                                        // R4
  end
endmodule

bind wave_issue_sched wis_checker #(.NUM_SIMD(NUM_SIMD), .SLOTS(SLOTS_PER_SIMD)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wave_valid  (wave_valid),
  .wave_cat    (wave_cat),
  .cat_busy    (cat_busy),
  .lds_busy    (lds_busy),
  .sel_simd    (sel_simd),
  .cat_grant   (cat_grant),
  .issue_grant (issue_grant)
);

// File: tb/tb_wave_issue_sched.sv
module tb_wave_issue_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4, SL = 8, NC = 5, CW = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NS*SL-1:0]    wave_valid = '0;
  logic [NS*SL*CW-1:0] wave_cat = '0;
  logic [NC-1:0]     cat_busy = '0;
  logic [NS-1:0]     lds_busy = '0;
  logic [1:0]        sel_simd;
  logic [NC*SL-1:0]  cat_grant;
  logic [SL-1:0]     issue_grant;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_issue_sched #(.NUM_SIMD(NS), .SLOTS_PER_SIMD(SL), .AGE_W(3)) dut (
    .clk(clk), .rst(rst), .wave_valid(wave_valid), .wave_cat(wave_cat),
    .cat_busy(cat_busy), .lds_busy(lds_busy), .sel_simd(sel_simd),
    .cat_grant(cat_grant), .issue_grant(issue_grant)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] slice(int c);
    return 32'(cat_grant[c*SL +: SL]);
  endfunction

  task automatic put(int simd, int slot, int cat);
    wave_valid[simd*SL + slot] = 1'b1;
    wave_cat[(simd*SL + slot)*CW +: CW] = CW'(cat);
  endtask

  task automatic clear_all();
    @(negedge clk);
    wave_valid = '0; wave_cat = '0; cat_busy = '0; lds_busy = '0;
  endtask

  task automatic wait_sel(int s);
    do @(negedge clk); while (int'(sel_simd) != s);
  endtask

  task automatic t_reset_rotate();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 sel after reset", 32'(sel_simd), 0);
    chk("R9 no grants after reset", 32'(issue_grant), 0);
    for (int k = 1; k < 9; k++) begin
      @(negedge clk); #1;
      chk("R1 rotation", 32'(sel_simd), 32'(k % 4));
    end
  endtask

  task automatic t_five_cats();
    clear_all();
    wait_sel(1);
    for (int c = 0; c < 5; c++) put(1, c, c);
    #1;
    chk("R4 five issue", 32'(issue_grant), 32'h1F);
    for (int c = 0; c < 5; c++) chk("R3 cat onehot", slice(c), 32'(1 << c));
  endtask

  task automatic t_other_simd();
    clear_all();
    wait_sel(1);
    put(2, 3, 0);
    #1;
    chk("R2 other simd not granted", 32'(issue_grant), 0);
    @(negedge clk); #1;
    chk("R2 own turn granted", slice(0), 32'h08);
  endtask

  task automatic t_tie();
    clear_all();
    wait_sel(3);
    put(3, 6, 2); put(3, 4, 2); put(3, 2, 2);
    #1;
    chk("R5 tie lower index", slice(2), 32'h04);
  endtask

  task automatic t_oldest_busy();
    clear_all();
    cat_busy[0] = 1'b1;
    put(0, 5, 0);
    repeat (2) @(negedge clk);
    put(0, 2, 0);
    wait_sel(0);
    #1;
    chk("R6 busy blocks", 32'(issue_grant), 0);
    cat_busy[0] = 1'b0;
    #1;
    chk("R5 oldest wins", slice(0), 32'h20);
  endtask

  task automatic t_bad_codes();
    clear_all();
    wait_sel(2);
    put(2, 0, 5); put(2, 1, 7);
    wave_cat[(2*SL + 2)*CW +: CW] = 3'd0;
    #1;
    chk("R6 invalid codes/slot", 32'(issue_grant), 0);
  endtask

  task automatic t_lds_pair();
    clear_all();
    lds_busy = 4'b0010;
    wait_sel(0);
    put(0, 3, 3); put(0, 4, 2);
    #1;
    chk("R7 partner blocks lds", slice(3), 0);
    chk("R7 scalar unaffected", slice(2), 32'h10);
    lds_busy = 4'b0100;
    #1;
    chk("R7 other pair no effect", slice(3), 32'h08);
    wait_sel(3);
    put(3, 0, 3);
    #1;
    chk("R7 simd3 blocked by simd2", slice(3), 0);
    lds_busy = 4'b0001;
    #1;
    chk("R7 simd3 free", slice(3), 32'h01);
  endtask

  task automatic t_saturate();
    clear_all();
    cat_busy[0] = 1'b1;
    put(1, 6, 0);
    repeat (12) @(negedge clk);
    put(1, 1, 0);
    repeat (12) @(negedge clk);
    wait_sel(1);
    cat_busy[0] = 1'b0;
    #1;
    chk("R8 saturated tie", slice(0), 32'h02);
  endtask

  task automatic t_reset_ages();
    clear_all();
    cat_busy[0] = 1'b1;
    put(2, 6, 0);
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    put(2, 1, 0);
    rst = 1'b0;
    #1;
    chk("R9 ptr zero", 32'(sel_simd), 0);
    wait_sel(2);
    cat_busy[0] = 1'b0;
    #1;
    chk("R9 ages cleared", slice(0), 32'h02);
  endtask

  initial begin
    t_reset_rotate();
    t_five_cats();
    t_other_simd();
    t_tie();
    t_oldest_busy();
    t_bad_codes();
    t_lds_pair();
    t_saturate();
    t_reset_ages();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule